// File: doc/BRIEF.md
# Pin Interrupt and Wake Detector

This block holds the event logic that sits behind one general-purpose I/O pin. The pin level first crosses into the clock domain through a short flop chain. The synchronized level is then compared against a trigger rule taken from a 32-bit control word. The rule is either edge or level, combined with active-high, active-low or both-edge polarity. When the rule fires and status capture is enabled, a sticky interrupt flag is set. Software clears that flag by writing a one to it.

The interrupt output follows the flag, gated by its own delivery enable. A wake request is raised while the flag is set and the system's present sleep state has its own wake enable bit set. A second sticky flag records that a wake request was seen. The same control word also stores the output value, the output enable and the two pull controls, and it shows the live synchronized pin level. Its reads are combinational and its writes take a whole word in one cycle.

Top module: `pin_event_ctrl`

## Requirements
- R1: After reset the control word reads 0x00000000, and `irq_o` and `wake_o` are low.
- R2: A write stores bits 8 to 15 and 20 to 23 of the written word. All other bits read as zero, except bit 16 (the synchronized pin level, which follows `pin_i` two clocks later), bit 28 and bit 29.
- R3: With bit 8 = 0 (edge mode), bits 10:9 pick the edge: 0 = rising, 1 = falling, 2 = either. A qualifying change of `pin_i` sets bit 28 on the third rising clock edge after the change.
- R4: With bit 8 = 1 (level mode), bits 10:9 = 0 or 1 set bit 28 on every cycle that the synchronized level is high or low respectively. Code 2 in level mode, and code 3 in either mode, never set bit 28.
- R5: Bit 28 is set only by an event that occurs while bit 11 (status capture enable) is 1.
- R6: `irq_o` equals bit 28 AND bit 12 (delivery enable). A set flag with bit 12 = 0 gives no interrupt.
- R7: Writing 1 to bit 28 clears it, and writing 0 leaves it. If an event occurs in the same cycle as the clear, the flag stays set, so an active level in level mode keeps it set.
- R8: `wake_o` is bit 28 AND the wake enable chosen by `sleep_i`: code 1 selects bit 13, code 2 selects bit 14, code 3 selects bit 15, and code 0 (running) never wakes.
- R9: Bit 29 sets on the clock edge after any cycle with `wake_o` high. Writing 1 to bit 29 clears it, and a new wake request in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 1 | Raw pin level, asynchronous to clk |
| sleep_i | input | 2 | Present sleep state: 0 running, 1 light idle, 2 suspend, 3 soft-off |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control word read value |
| irq_o | output | 1 | Interrupt delivery output |
| wake_o | output | 1 | Wake request |

## Verification
Two pairs of functions can land on the same clock edge: a software clear of the interrupt flag together with a fresh trigger event, and a clear of the wake flag together with a live wake request. The bench provokes the first case in two ways. It times a write-one clear to land on the exact edge where a delayed rising edge is detected, and it also issues a clear while a level-mode trigger is still active. In both cases the flag must read set afterwards. A behavioural model, stepped on every clock, judges each of these cycles together with the surrounding ones.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;
  localparam int CW = 32;

  localparam int TRIG_B   = 8;
  localparam int POL_LO   = 9;
  localparam int STSEN_B  = 11;
  localparam int DLVEN_B  = 12;
  localparam int WK_IDLE  = 13;
  localparam int WK_SUSP  = 14;
  localparam int WK_OFF   = 15;
  localparam int LVL_B    = 16;
  localparam int IST_B    = 28;
  localparam int WST_B    = 29;

  // Stored configuration bits: trigger, polarity, enables, wake enables,
  // pulls, output value and output enable.
  localparam logic [CW-1:0] WR_MASK = 32'h00F0_FF00;

  typedef enum logic [1:0] {
    POL_HIGH = 2'd0,
    POL_LOW  = 2'd1,
    POL_BOTH = 2'd2,
    POL_RSVD = 2'd3
  } pol_e;

  typedef enum logic [1:0] {
    SLP_RUN  = 2'd0,
    SLP_IDLE = 2'd1,
    SLP_SUSP = 2'd2,
    SLP_OFF  = 2'd3
  } slp_e;
endpackage

// File: rtl/pin_rst_sync.sv
module pin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [1:0] q;
  logic [1:0] q_nxt;

  always_comb q_nxt = {q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign rst_ok = q[1];
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic level_o,
  output logic prev_o
);
  localparam int N = STAGES + 1;

  logic [N-1:0] chain;
  logic [N-1:0] chain_nxt;

  generate
    for (genvar i = 0; i < N; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb chain_nxt[i] = d;
      end else begin : g_rest
        always_comb chain_nxt[i] = chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= chain_nxt;
  end

  assign level_o = chain[STAGES-1];
  assign prev_o  = chain[STAGES];
endmodule

// File: rtl/pin_trig_detect.sv
module pin_trig_detect
  import pin_evt_pkg::*;
(
  input  logic       level,
  input  logic       prev,
  input  logic       lvl_mode,
  input  logic [1:0] pol,
  output logic       event_o
);
  always_comb begin
    event_o = 1'b0;
    if (lvl_mode) begin
      case (pol_e'(pol))
        POL_HIGH: event_o = level;
        POL_LOW:  event_o = ~level;
        default:  event_o = 1'b0;
      endcase
    end else begin
      case (pol_e'(pol))
        POL_HIGH: event_o = level & ~prev;
        POL_LOW:  event_o = ~level & prev;
        POL_BOTH: event_o = level ^ prev;
        default:  event_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pin_ctrl_regs.sv
module pin_ctrl_regs
  import pin_evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  input  logic          evt,
  input  logic          level,
  input  logic [1:0]    sleep,
  output logic [CW-1:0] cfg_o,
  output logic [CW-1:0] rdata,
  output logic          irq,
  output logic          wake
);
  logic [CW-1:0] cfg_q, cfg_nxt;
  logic          ist_q, ist_nxt;
  logic          wst_q, wst_nxt;
  logic          wk_en;

  always_comb begin
    case (slp_e'(sleep))
      SLP_IDLE: wk_en = cfg_q[WK_IDLE];
      SLP_SUSP: wk_en = cfg_q[WK_SUSP];
      SLP_OFF:  wk_en = cfg_q[WK_OFF];
      default:  wk_en = 1'b0;
    endcase
  end

  assign irq  = ist_q & cfg_q[DLVEN_B];
  assign wake = ist_q & wk_en;

  always_comb begin
    cfg_nxt = cfg_q;
    if (we) cfg_nxt = wdata & WR_MASK;

    ist_nxt = ist_q;
    if (we && wdata[IST_B]) ist_nxt = 1'b0;
    if (evt && cfg_q[STSEN_B]) ist_nxt = 1'b1;

    wst_nxt = wst_q;
    if (we && wdata[WST_B]) wst_nxt = 1'b0;
    if (wake) wst_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ist_q <= 1'b0;
      wst_q <= 1'b0;
    end else begin
      cfg_q <= cfg_nxt;
      ist_q <= ist_nxt;
      wst_q <= wst_nxt;
    end
  end

  always_comb begin
    rdata        = cfg_q;
    rdata[LVL_B] = level;
    rdata[IST_B] = ist_q;
    rdata[WST_B] = wst_q;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
  import pin_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_i,
  input  logic [1:0]    sleep_i,
  input  logic          reg_we,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          irq_o,
  output logic          wake_o
);
  logic          rst_ok;
  logic          lvl, prv, evt;
  logic [CW-1:0] cfg;

  pin_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_ok(rst_ok)
  );

  pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_ok),
    .d      (pin_i),
    .level_o(lvl),
    .prev_o (prv)
  );

  pin_trig_detect u_det (
    .level   (lvl),
    .prev    (prv),
    .lvl_mode(cfg[TRIG_B]),
    .pol     (cfg[POL_LO+1:POL_LO]),
    .event_o (evt)
  );

  pin_ctrl_regs u_regs (
    .clk  (clk),
    .rst_n(rst_ok),
    .we   (reg_we),
    .wdata(reg_wdata),
    .evt  (evt),
    .level(lvl),
    .sleep(sleep_i),
    .cfg_o(cfg),
    .rdata(reg_rdata),
    .irq  (irq_o),
    .wake (wake_o)
  );
endmodule

// File: rtl/pin_event_chk.sv
module pin_event_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic [1:0] sleep,
  input logic       clr_int,
  input logic       sts,
  input logic       wsts,
  input logic       sts_en,
  input logic       dlv_en,
  input logic       irq_o,
  input logic       wake_o
);
  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_o == (sts && dlv_en));

  // R7
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (sts && !clr_int) |=> sts);

  // R5
  no_latch_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!sts && !sts_en) |=> !sts);

  // R9
  wake_flag_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    wake_o |=> wsts);

  // R8
  run_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (sleep == 2'd0) |-> !wake_o);
endmodule

bind pin_event_ctrl pin_event_chk u_chk (
  .clk    (clk),
  .rst_ok (rst_ok),
  .sleep  (sleep_i),
  .clr_int(reg_we && reg_wdata[28]),
  .sts    (reg_rdata[28]),
  .wsts   (reg_rdata[29]),
  .sts_en (reg_rdata[11]),
  .dlv_en (reg_rdata[12]),
  .irq_o  (irq_o),
  .wake_o (wake_o)
);

// File: tb/tb_pin_event_ctrl.sv
module tb_pin_event_ctrl;
  localparam int CLK_P = 10;
  localparam logic [31:0] CLR = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_i = 1'b0;
  logic [1:0]  sleep_i = 2'd0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o, wake_o;

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc = 0;
  string cur = "R1";

  pin_event_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sleep_i(sleep_i),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [31:0] m_cfg;
  bit m_int, m_wk, m_l1, m_l2, m_l3;
  int rcnt = 0;

  function automatic bit m_event(logic [31:0] c, bit l, bit p);
    if (c[8]) return (c[10:9] == 2'd0) ? l : (c[10:9] == 2'd1) ? !l : 1'b0;
    case (c[10:9])
      2'd0: return l && !p;
      2'd1: return !l && p;
      2'd2: return l != p;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_match(logic [31:0] c, logic [1:0] s);
    if (s == 2'd1) return c[13];
    if (s == 2'd2) return c[14];
    if (s == 2'd3) return c[15];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    bit ev, wr;
    cyc++;
    if (!rst_n || rcnt < 2) begin
      m_cfg = '0; m_int = 0; m_wk = 0; m_l1 = 0; m_l2 = 0; m_l3 = 0;
      rcnt = rst_n ? rcnt + 1 : 0;
    end else begin
      ev = m_event(m_cfg, m_l2, m_l3);
      wr = reg_we;
      m_wk  = (m_int && m_match(m_cfg, sleep_i)) || (m_wk && !(wr && reg_wdata[29]));
      m_int = (ev && m_cfg[11]) || (m_int && !(wr && reg_wdata[28]));
      if (wr) m_cfg = reg_wdata & 32'h00F0_FF00;
      m_l3 = m_l2; m_l2 = m_l1; m_l1 = pin_i;
    end
    #(CLK_P/4);
    chk(cur, "rdata(model)", reg_rdata,
        m_cfg | (32'(m_l2) << 16) | (32'(m_int) << 28) | (32'(m_wk) << 29));
    chk(cur, "irq(model)", 32'(irq_o), 32'(m_int && m_cfg[12]));
    chk(cur, "wake(model)", 32'(wake_o), 32'(m_int && m_match(m_cfg, sleep_i)));
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(3);
    // R1
    chk("R1", "rdata after reset", reg_rdata, 32'h0);
    chk("R1", "irq after reset", 32'(irq_o), 32'h0);
    chk("R1", "wake after reset", 32'(wake_o), 32'h0);

    cur = "R2";
    wr(32'hFFFF_FFFF);
    chk("R2", "masked readback", reg_rdata, 32'h00F0_FF00);
    wr(32'h0);
    chk("R2", "zero readback", reg_rdata, 32'h0);
    pin_i = 1'b1; step(2);
    chk("R2", "pin level bit16 high", 32'(reg_rdata[16]), 32'h1);
    pin_i = 1'b0; step(2);
    chk("R2", "pin level bit16 low", 32'(reg_rdata[16]), 32'h0);

    cur = "R3";
    wr(32'h1800);
    pin_i = 1'b1; step(2);
    chk("R3", "rising not yet latched", 32'(reg_rdata[28]), 32'h0);
    step(1);
    chk("R3", "rising latched on third edge", 32'(reg_rdata[28]), 32'h1);
    pin_i = 1'b0; step(3);
    chk("R3", "edge flag sticky", 32'(reg_rdata[28]), 32'h1);
    wr(32'h1800 | CLR);
    wr(32'h1A00);
    pin_i = 1'b1; step(3);
    chk("R3", "falling mode ignores rise", 32'(reg_rdata[28]), 32'h0);
    pin_i = 1'b0; step(3);
    chk("R3", "falling mode latches fall", 32'(reg_rdata[28]), 32'h1);
    wr(32'h1C00 | CLR);
    pin_i = 1'b1; step(3);
    chk("R3", "both-edge rise", 32'(reg_rdata[28]), 32'h1);
    wr(32'h1C00 | CLR);
    pin_i = 1'b0; step(3);
    chk("R3", "both-edge fall", 32'(reg_rdata[28]), 32'h1);

    cur = "R4";
    wr(32'h1E00 | CLR);
    pin_i = 1'b1; step(3);
    pin_i = 1'b0; step(3);
    chk("R4", "edge code 3 never fires", 32'(reg_rdata[28]), 32'h0);
    wr(32'h1900);
    step(2);
    chk("R4", "level high idle", 32'(reg_rdata[28]), 32'h0);
    pin_i = 1'b1; step(3);
    chk("R4", "level high fires", 32'(reg_rdata[28]), 32'h1);
    pin_i = 1'b0; step(3);
    wr(32'h1900 | CLR);
    wr(32'h1B00);
    step(1);
    chk("R4", "level low fires", 32'(reg_rdata[28]), 32'h1);
    pin_i = 1'b1; step(3);
    wr(32'h1D00 | CLR);
    step(3);
    pin_i = 1'b0; step(3);
    chk("R4", "level with code 2 never fires", 32'(reg_rdata[28]), 32'h0);

    cur = "R5";
    wr(32'h1000);
    pin_i = 1'b1; step(3);
    chk("R5", "no latch without capture enable", 32'(reg_rdata[28]), 32'h0);
    chk("R5", "no irq without capture enable", 32'(irq_o), 32'h0);
    pin_i = 1'b0; step(3);

    cur = "R6";
    wr(32'h0800);
    pin_i = 1'b1; step(3);
    chk("R6", "flag set, delivery off", 32'(reg_rdata[28]), 32'h1);
    chk("R6", "irq gated off", 32'(irq_o), 32'h0);
    wr(32'h1800);
    chk("R6", "irq on after delivery enable", 32'(irq_o), 32'h1);
    wr(32'h0800 | CLR);
    pin_i = 1'b0; step(3);

    cur = "R7";
    wr(32'h1800);
    pin_i = 1'b1; step(3);
    pin_i = 1'b0; step(3);
    wr(32'h1800);
    chk("R7", "write 0 keeps flag", 32'(reg_rdata[28]), 32'h1);
    pin_i = 1'b1; step(2);
    wr(32'h1800 | CLR);
    chk("R7", "event beats clear", 32'(reg_rdata[28]), 32'h1);
    wr(32'h1800 | CLR);
    chk("R7", "clear without event", 32'(reg_rdata[28]), 32'h0);
    wr(32'h1900);
    step(1);
    wr(32'h1900 | CLR);
    chk("R7", "active level reasserts", 32'(reg_rdata[28]), 32'h1);
    pin_i = 1'b0; step(3);
    wr(32'h1800 | CLR);
    chk("R7", "cleared after level gone", 32'(reg_rdata[28]), 32'h0);

    cur = "R8";
    wr(32'h4800);
    sleep_i = 2'd2;
    pin_i = 1'b1; step(3);
    chk("R8", "wake in suspend", 32'(wake_o), 32'h1);
    chk("R9", "wake flag not yet", 32'(reg_rdata[29]), 32'h0);
    step(1);
    chk("R9", "wake flag set", 32'(reg_rdata[29]), 32'h1);
    sleep_i = 2'd1; #1;
    chk("R8", "idle not enabled", 32'(wake_o), 32'h0);
    sleep_i = 2'd3; #1;
    chk("R8", "off not enabled", 32'(wake_o), 32'h0);
    sleep_i = 2'd0; #1;
    chk("R8", "running never wakes", 32'(wake_o), 32'h0);
    step(1);
    cur = "R9";
    wr(32'h4800 | CLR | 32'h2000_0000);
    chk("R9", "both flags cleared", 32'(reg_rdata[29:28]), 32'h0);
    cur = "R8";
    wr(32'h8800);
    sleep_i = 2'd3;
    pin_i = 1'b0; step(3);
    pin_i = 1'b1; step(3);
    chk("R8", "wake in soft-off", 32'(wake_o), 32'h1);
    step(1);
    cur = "R9";
    wr(32'h8800 | CLR | 32'h2000_0000);
    chk("R9", "clear loses to live wake", 32'(reg_rdata[29]), 32'h1);
    sleep_i = 2'd0;
    step(1);
    wr(32'h0800 | CLR | 32'h2000_0000);
    chk("R9", "wake flag cleared", 32'(reg_rdata[29:28]), 32'h0);
    step(2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule